// File: doc/BRIEF.md
# Serial Peripheral Master with Three-Speed Clock

This block is the only master on a serial peripheral bus. It moves one 8-bit byte out on MOSI while it brings one byte in from MISO, and it drives the serial clock and an active-low select for the attached slaves. A request on the parallel side starts one framed byte transfer. A 2-bit speed code, captured when the transfer starts, divides the system clock by 4, 16 or 64 to make the serial clock.

The parallel side has a start strobe, a transmit byte, a busy flag, a one-cycle completion pulse and a received-byte register that holds its value between transfers. The serial side works in clock mode 0 with the most significant bit first. The transmit byte is loaded into a shift register that serves both directions. The finished receive byte is copied into a separate hold register.

Top module: `spi_rate_master`

## Requirements
- R1: While reset is asserted and right after it is released, `cs_n_o` is 1, `sck_o` is 0, `busy_o` is 0, `done_o` is 0 and `rx_byte_o` is 0x00.
- R2: Speed code 2'b00 gives a serial clock period of 4 system clock cycles, so the half period H is 2.
- R3: Speed code 2'b01 gives a serial clock period of 16 system clock cycles (H = 8).
- R4: Speed codes 2'b11 and 2'b10 both give a serial clock period of 64 system clock cycles (H = 32).
- R5: The speed code is captured in the cycle that accepts `start_i`. Changing it during a transfer has no effect on that transfer.
- R6: `sck_o` rests low. MOSI changes only after falling edges of `sck_o` and keeps its value while `sck_o` is high. The transmit byte goes out MSB first, and exactly 8 rising edges occur per transfer.
- R7: MISO is sampled on each rising edge of `sck_o`, MSB first. The assembled byte appears on `rx_byte_o` in the same cycle as `done_o` and holds until the next completion.
- R8: `cs_n_o` falls H cycles before the first rising edge of `sck_o` and rises H cycles after the last falling edge. `sck_o` is low whenever `cs_n_o` is high, and `cs_n_o` is low exactly while `busy_o` is high.
- R9: `busy_o` is high for exactly 17*H cycles. It rises on the clock edge that accepts `start_i`.
- R10: `done_o` is high for exactly one cycle: the first cycle after `busy_o` falls.
- R11: A `start_i` pulse that arrives while `busy_o` is high is ignored. The running byte is not changed and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (accepted only while idle) |
| rate_sel_i | input | 2 | Serial clock speed code |
| tx_byte_i | input | 8 | Byte to send, captured with start |
| rx_byte_o | output | 8 | Last received byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data to slave |
| miso_i | input | 1 | Serial data from slave |

## Verification
The bench sweeps all four speed codes over a set of byte pairs that includes all-zeros, all-ones and alternating patterns. A behavioural slave captures MOSI and returns its own byte on MISO. The bench measures the serial clock period, the select lead and trail times and the busy length against values it computes from the speed code. A divider that decoded the reserved code wrongly would give the wrong period. A lost or extra bit would shift the received byte. A select timed wrongly would move the lead or trail time. One transfer per speed changes the speed code and pulses start in the middle of the transfer. A design that re-read the code would stretch or shrink the clock, and one that accepted the second start would corrupt the byte or stay busy too long.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_SHIFT = 2'd2,
    PH_TRAIL = 2'd3
  } phase_t;

  localparam logic [1:0] RATE_FAST = 2'b00;
  localparam logic [1:0] RATE_MID  = 2'b01;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == limit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          capture_i,
  input  logic          miso_i,
  output logic          mosi_o,
  output logic [DW-1:0] rx_hold_o
);

  logic [DW-1:0] shreg_q, shreg_d;
  logic          samp_q, samp_d;
  logic [DW-1:0] hold_q, hold_d;

  assign mosi_o    = shreg_q[DW-1];
  assign rx_hold_o = hold_q;

  always_comb begin
    shreg_d = shreg_q;
    samp_d  = samp_q;
    hold_d  = hold_q;
    if (load_i) begin
      shreg_d = load_data_i;
    end else if (fall_i) begin
      shreg_d = {shreg_q[DW-2:0], samp_q};
    end
    if (rise_i) begin
      samp_d = miso_i;
    end
    if (capture_i) begin
      hold_d = shreg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      samp_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      shreg_q <= shreg_d;
      samp_q  <= samp_d;
      hold_q  <= hold_d;
    end
  end

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_rate_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64,
  localparam int CNT_W   = $clog2(DIV_SLOW / 2),
  localparam int BIT_W   = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       rate_sel_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic [CNT_W-1:0] half_m1_o,
  output logic             load_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             capture_o,
  output logic             sck_o,
  output logic             cs_n_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] HM1_FAST = CNT_W'(DIV_FAST / 2 - 1);
  localparam logic [CNT_W-1:0] HM1_MID  = CNT_W'(DIV_MID / 2 - 1);
  localparam logic [CNT_W-1:0] HM1_SLOW = CNT_W'(DIV_SLOW / 2 - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

  phase_t           ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CNT_W-1:0] hm1_q, hm1_d;
  logic             sck_q, sck_d;
  logic             csn_q, csn_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] hm1_pick;

  always_comb begin
    case (rate_sel_i)
      RATE_FAST: hm1_pick = HM1_FAST;
      RATE_MID:  hm1_pick = HM1_MID;
      default:   hm1_pick = HM1_SLOW;
    endcase
  end

  always_comb begin
    ph_d      = ph_q;
    bit_d     = bit_q;
    hm1_d     = hm1_q;
    sck_d     = sck_q;
    csn_d     = csn_q;
    done_d    = 1'b0;
    load_o    = 1'b0;
    rise_o    = 1'b0;
    fall_o    = 1'b0;
    capture_o = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d   = PH_LEAD;
          hm1_d  = hm1_pick;
          csn_d  = 1'b0;
          bit_d  = '0;
          load_o = 1'b1;
        end
      end
      PH_LEAD: begin
        if (tick_i) begin
          ph_d   = PH_SHIFT;
          sck_d  = 1'b1;
          rise_o = 1'b1;
        end
      end
      PH_SHIFT: begin
        if (tick_i) begin
          if (sck_q) begin
            sck_d  = 1'b0;
            fall_o = 1'b1;
            if (bit_q == LAST_BIT) begin
              ph_d = PH_TRAIL;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            sck_d  = 1'b1;
            rise_o = 1'b1;
          end
        end
      end
      PH_TRAIL: begin
        if (tick_i) begin
          ph_d      = PH_IDLE;
          csn_d     = 1'b1;
          done_d    = 1'b1;
          capture_o = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      hm1_q  <= HM1_SLOW;
      sck_q  <= 1'b0;
      csn_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      hm1_q  <= hm1_d;
      sck_q  <= sck_d;
      csn_q  <= csn_d;
      done_q <= done_d;
    end
  end

  assign run_o     = (ph_q != PH_IDLE);
  assign half_m1_o = hm1_q;
  assign sck_o     = sck_q;
  assign cs_n_o    = csn_q;
  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = done_q;

endmodule

// File: rtl/spi_rate_master.sv
module spi_rate_master #(
  parameter int DW       = 8,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    rate_sel_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic [DW-1:0] rx_byte_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          sck_o,
  output logic          cs_n_o,
  output logic          mosi_o,
  input  logic          miso_i
);

  localparam int CNT_W = $clog2(DIV_SLOW / 2);

  logic             run;
  logic             tick;
  logic [CNT_W-1:0] half_m1;
  logic             load, rise, fall, capture;

  spi_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .limit_i (half_m1),
    .tick_o  (tick)
  );

  spi_frame_ctrl #(
    .DW       (DW),
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rate_sel_i (rate_sel_i),
    .tick_i     (tick),
    .run_o      (run),
    .half_m1_o  (half_m1),
    .load_o     (load),
    .rise_o     (rise),
    .fall_o     (fall),
    .capture_o  (capture),
    .sck_o      (sck_o),
    .cs_n_o     (cs_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  spi_shift_engine #(.DW(DW)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .load_data_i (tx_byte_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .capture_i   (capture),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_hold_o   (rx_byte_o)
  );

endmodule

// File: rtl/spi_rate_master_chk.sv
module spi_rate_master_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             sck,
  input logic             cs_n,
  input logic             mosi,
  input logic [CNT_W-1:0] half_m1
);

  // R8: clock rests low while deselected
  a_r8_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R8: select low exactly during busy
  a_r8_cs_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: completion immediately follows the end of busy
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6: MOSI steady while the clock is high
  a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R5: captured speed held through a transfer
  a_r5_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(half_m1));

endmodule

bind spi_rate_master spi_rate_master_chk #(.CNT_W($clog2(DIV_SLOW / 2))) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy_o),
  .done    (done_o),
  .sck     (sck_o),
  .cs_n    (cs_n_o),
  .mosi    (mosi_o),
  .half_m1 (half_m1)
);

// File: tb/test_spi_rate_master.sv
`timescale 1ns/1ps
module test_spi_rate_master;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [1:0] rate_sel;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;
  logic       busy, done, sck, cs_n, mosi;
  logic       miso;

  int checks = 0;
  int failures = 0;

  time t_csf, t_csr, t_rise_first, t_rise_last, t_fall_last;
  int  n_rise;
  logic [7:0] slave_pat;
  logic [7:0] slave_rx;

  always #4 clk = ~clk;

  spi_rate_master i_spi_rate_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .rate_sel_i (rate_sel),
    .tx_byte_i  (tx_byte),
    .rx_byte_o  (rx_byte),
    .busy_o     (busy),
    .done_o     (done),
    .sck_o      (sck),
    .cs_n_o     (cs_n),
    .mosi_o     (mosi),
    .miso_i     (miso)
  );

  // behavioural mode-0 slave
  always @(negedge cs_n) begin
    t_csf = $time;
    miso  = slave_pat[7];
  end
  always @(posedge cs_n) t_csr = $time;
  always @(posedge sck) begin
    if (n_rise == 0) t_rise_first = $time;
    t_rise_last = $time;
    n_rise      = n_rise + 1;
    slave_rx    = {slave_rx[6:0], mosi};
  end
  always @(negedge sck) begin
    t_fall_last = $time;
    slave_pat   = {slave_pat[6:0], 1'b0};
    miso        = slave_pat[7];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int div_for(input logic [1:0] code);
    if (code == 2'b00) return 4;
    if (code == 2'b01) return 16;
    return 64;
  endfunction

  task automatic do_xfer(input logic [1:0] code, input logic [7:0] txv,
                         input logic [7:0] pat, input bit disturb);
    int h;
    int cnt;
    string rtag;
    h = div_for(code) / 2;
    rtag = (code == 2'b00) ? "R2" : (code == 2'b01) ? "R3" : "R4";
    @(negedge clk);
    slave_pat = pat;
    slave_rx  = 8'h00;
    n_rise    = 0;
    rate_sel  = code;
    tx_byte   = txv;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (busy === 1'b1 && cnt < 5000) begin
      cnt++;
      if (disturb && cnt == 3) begin
        rate_sel = ~code;        // R5 / R11 disturbance
        tx_byte  = ~txv;
        start    = 1'b1;
      end else if (disturb && cnt == 5) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(cnt == 17 * h, disturb ? "R9/R5/R11 busy length" : "R9 busy length", cnt, 17 * h);
    chk(done === 1'b1, "R10 done after busy", int'(done), 1);
    chk(rx_byte === pat, disturb ? "R7/R11 rx byte" : "R7 rx byte", int'(rx_byte), int'(pat));
    chk(slave_rx === txv, disturb ? "R6/R11 mosi byte" : "R6 mosi byte", int'(slave_rx), int'(txv));
    chk(n_rise == 8, "R6 rising edge count", n_rise, 8);
    chk((t_rise_last - t_rise_first) == 7 * 2 * h * 8,
        disturb ? "R5 period held" : rtag, int'((t_rise_last - t_rise_first) / 56), 2 * h);
    chk((t_rise_first - t_csf) == h * 8, "R8 select lead", int'((t_rise_first - t_csf) / 8), h);
    chk((t_csr - t_fall_last) == h * 8, "R8 select trail", int'((t_csr - t_fall_last) / 8), h);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", int'(done), 0);
    chk(busy === 1'b0 && cs_n === 1'b1, "R11 no second transfer", int'(busy), 0);
    chk(rx_byte === pat, "R7 rx held", int'(rx_byte), int'(pat));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    start     = 1'b0;
    rate_sel  = 2'b00;
    tx_byte   = 8'h00;
    miso      = 1'b0;
    slave_pat = 8'h00;
    slave_rx  = 8'h00;
    n_rise    = 0;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0, "R1 serial idle in reset", int'({cs_n, sck}), 2);
    chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_byte === 8'h00, "R1 rx after reset", int'(rx_byte), 0);
    chk(cs_n === 1'b1 && busy === 1'b0, "R1 idle after reset", int'({cs_n, busy}), 2);

    for (int code = 0; code < 4; code++) begin
      for (int i = 0; i < 10; i++) begin
        logic [7:0] txv;
        logic [7:0] pat;
        case (i)
          0: begin txv = 8'h00; pat = 8'hFF; end
          1: begin txv = 8'hFF; pat = 8'h00; end
          2: begin txv = 8'hA5; pat = 8'h5A; end
          default: begin
            txv = 8'((i * 37 + code * 53 + 11) & 8'hFF);
            pat = 8'((i * 91 + code * 29 + 7) & 8'hFF);
          end
        endcase
        do_xfer(2'(code), txv, pat, i == 4);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule